// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns a decoded single-transfer instruction (one word or one byte, load or store) into a memory access request and a base-register update. Each access gets one instruction strobe. The strobe comes with the current base value and an offset register value that has already been shifted. The block keeps the instruction's control bits. One cycle later it presents the access address, the byte/word and read/write controls, and the base writeback value. The writeback enable is qualified by an abort indication that arrives in that same access cycle.

The block drives a user-translation signal from the current processor mode. The signal is forced low for the access cycle of a post-indexed transfer that also has the writeback bit set. A register-offset encoding with bit 4 set is reported as undefined and produces no access. Read data returned for the access is formatted here: a byte load picks the addressed byte lane and zero-extends it.

Top module: `ldst_agu`

## Requirements
- R1: A strobed instruction is one of this block's transfers when bits [27:25] are 3'b010 (immediate form, offset = bits [11:0] zero-extended) or 3'b011 (register form, offset = `roff_i`). In both forms bit 24 = pre-index, bit 23 = add, bit 22 = byte, bit 21 = writeback and bit 20 = load. Any other code produces neither an access nor an undefined flag.
- R2: A pre-indexed access uses base ± offset as its address. The writeback enable is raised only when bit 21 is set, and it then carries that same address.
- R3: A post-indexed access uses the unmodified base as its address. It always raises the writeback enable with base ± offset, whatever bit 21 holds.
- R4: During the access cycle of a post-indexed transfer with bit 21 set, `trans_o` is 0.
- R5: At all other times `trans_o` is 1 when `mode_i[1:0]` is nonzero and 0 otherwise.
- R6: When `abort_i` is high in the access cycle, `wb_en_o` stays low.
- R7: A register-form instruction with bit 4 set raises `undef_o` for one cycle and gives no access and no writeback. An immediate-form instruction is never undefined, whatever bit 4 holds.
- R8: Outputs appear in the cycle after the strobe, and `acc_valid_o` is high for exactly one cycle per strobe. After reset `acc_valid_o`, `wb_en_o` and `undef_o` are 0.
- R9: `acc_byte_o` equals bit 22 and `acc_write_o` is the inverse of bit 20.
- R10: A byte access returns `ld_data_o` = byte lane `acc_addr_o[1:0]` of `rdata_i` (lane k = bits 8k+7:8k), zero-extended. A word access returns `rdata_i` unchanged.
- R11: Address arithmetic wraps modulo 2^32; for example, base 4 minus offset 8 gives 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| roff_i | input | 32 | Shifted register offset |
| mode_i | input | 5 | Current processor mode |
| abort_i | input | 1 | Transfer abort, sampled in the access cycle |
| rdata_i | input | 32 | Read data for the access |
| acc_valid_o | output | 1 | Access request |
| acc_addr_o | output | 32 | Access address |
| acc_byte_o | output | 1 | Byte access |
| acc_write_o | output | 1 | Store access |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Base writeback value |
| trans_o | output | 1 | Privileged translation (low = user) |
| undef_o | output | 1 | Undefined instruction |
| ld_data_o | output | 32 | Formatted load data |

## Verification
The bench contrasts pre- and post-indexing with the writeback bit both set and clear. A design that confused the two would either address with the updated base or fail to write back a post-indexed base. An abort raised on a post-indexed access checks that the base update is dropped, where a faulty design would corrupt the base. The bench applies bit 4 in both offset forms, which catches a decoder that marks immediate offsets as undefined. A subtract that underflows and byte loads from a nonzero lane expose arithmetic that does not wrap and lane selection that always takes the low byte. `trans_o` is checked during and after a post-indexed writeback access, so a signal that stays low or never drops is reported.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned IMM_W  = 12;
    localparam int unsigned MODE_W = 5;

    // instruction field positions
    localparam int unsigned B_PRE   = 24;
    localparam int unsigned B_UP    = 23;
    localparam int unsigned B_BYTE  = 22;
    localparam int unsigned B_WB    = 21;
    localparam int unsigned B_LOAD  = 20;
    localparam int unsigned B_SHREG = 4;
    localparam logic [2:0]  GRP_IMM = 3'b010;
    localparam logic [2:0]  GRP_REG = 3'b011;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_IMM  = 2'd1,
        FORM_REG  = 2'd2
    } agu_form_t;

    typedef struct packed {
        logic pre;
        logic up;
        logic byte_acc;
        logic wb;
        logic load;
    } agu_bits_t;

    typedef struct packed {
        agu_form_t form;
        agu_bits_t bits;
        logic      undef;
    } agu_dec_t;

    function automatic logic mode_privileged(input logic [MODE_W-1:0] m);
        return m[1:0] != 2'b00;
    endfunction

endpackage

// File: rtl/agu_decode.sv
module agu_decode
    import ldst_agu_pkg::*;
#(
    parameter int unsigned IW = XLEN
) (
    input  logic [IW-1:0] instr,
    output agu_dec_t      dec
);
    logic [2:0] grp;

    always_comb begin
        grp           = instr[27:25];
        dec.bits.pre      = instr[B_PRE];
        dec.bits.up       = instr[B_UP];
        dec.bits.byte_acc = instr[B_BYTE];
        dec.bits.wb       = instr[B_WB];
        dec.bits.load     = instr[B_LOAD];
        unique case (grp)
            GRP_IMM: dec.form = FORM_IMM;
            GRP_REG: dec.form = FORM_REG;
            default: dec.form = FORM_NONE;
        endcase
        dec.undef = (dec.form == FORM_REG) && instr[B_SHREG];
    end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import ldst_agu_pkg::*;
#(
    parameter int unsigned AW   = XLEN,
    parameter int unsigned OFFW = IMM_W
) (
    input  agu_form_t     form,
    input  agu_bits_t     bits,
    input  logic [AW-1:0] base,
    input  logic [OFFW-1:0] imm,
    input  logic [AW-1:0] roff,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wb_data,
    output logic          wb_req,
    output logic          force_user
);
    logic [AW-1:0] offset;
    logic [AW-1:0] moved;

    always_comb begin
        offset     = (form == FORM_IMM) ? {{(AW-OFFW){1'b0}}, imm} : roff;
        moved      = bits.up ? (base + offset) : (base - offset);
        addr       = bits.pre ? moved : base;
        wb_data    = moved;
        wb_req     = bits.pre ? bits.wb : 1'b1;
        force_user = !bits.pre && bits.wb;
    end
endmodule

// File: rtl/agu_load_fmt.sv
module agu_load_fmt
    import ldst_agu_pkg::*;
#(
    parameter int unsigned DW = XLEN
) (
    input  logic                         byte_acc,
    input  logic [$clog2(DW/8)-1:0]      lane,
    input  logic [DW-1:0]                rdata,
    output logic [DW-1:0]                ldata
);
    localparam int unsigned LANES = DW / 8;

    logic [7:0] lane_bytes [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_bytes[g] = rdata[8*g +: 8];
        end
    endgenerate

    always_comb begin
        if (byte_acc) ldata = {{(DW-8){1'b0}}, lane_bytes[lane]};
        else          ldata = rdata;
    end
endmodule

// File: rtl/agu_trans_ctrl.sv
module agu_trans_ctrl
    import ldst_agu_pkg::*;
#(
    parameter int unsigned MW = MODE_W
) (
    input  logic [MW-1:0] mode,
    input  logic          active,
    input  logic          force_user,
    output logic          trans
);
    always_comb trans = (active && force_user) ? 1'b0 : mode_privileged(mode);
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   roff_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              abort_i,
    input  logic [XLEN-1:0]   rdata_i,
    output logic              acc_valid_o,
    output logic [XLEN-1:0]   acc_addr_o,
    output logic              acc_byte_o,
    output logic              acc_write_o,
    output logic              wb_en_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              trans_o,
    output logic              undef_o,
    output logic [XLEN-1:0]   ld_data_o
);
    localparam int unsigned LANE_W = $clog2(XLEN/8);

    agu_dec_t        dec;
    logic [XLEN-1:0] addr_c, wbd_c;
    logic            wbreq_c, force_c;
    logic            is_xfer;

    logic            valid_q, undef_q, byte_q, write_q, wbreq_q, force_q, pre_q;
    logic [XLEN-1:0] addr_q, wbd_q;

    agu_decode #(.IW(XLEN)) u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    agu_addr_calc #(.AW(XLEN), .OFFW(IMM_W)) u_calc (
        .form       (dec.form),
        .bits       (dec.bits),
        .base       (base_i),
        .imm        (instr_i[IMM_W-1:0]),
        .roff       (roff_i),
        .addr       (addr_c),
        .wb_data    (wbd_c),
        .wb_req     (wbreq_c),
        .force_user (force_c)
    );

    assign is_xfer = (dec.form != FORM_NONE) && !dec.undef;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            undef_q <= 1'b0;
            byte_q  <= 1'b0;
            write_q <= 1'b0;
            wbreq_q <= 1'b0;
            force_q <= 1'b0;
            pre_q   <= 1'b0;
            addr_q  <= '0;
            wbd_q   <= '0;
        end else begin
            valid_q <= dec_valid_i && is_xfer;
            undef_q <= dec_valid_i && dec.undef;
            if (dec_valid_i) begin
                byte_q  <= dec.bits.byte_acc;
                write_q <= !dec.bits.load;
                wbreq_q <= wbreq_c && is_xfer;
                force_q <= force_c && is_xfer;
                pre_q   <= dec.bits.pre;
                addr_q  <= addr_c;
                wbd_q   <= wbd_c;
            end
        end
    end

    agu_trans_ctrl #(.MW(MODE_W)) u_trans (
        .mode       (mode_i),
        .active     (valid_q),
        .force_user (force_q),
        .trans      (trans_o)
    );

    agu_load_fmt #(.DW(XLEN)) u_fmt (
        .byte_acc (byte_q),
        .lane     (addr_q[LANE_W-1:0]),
        .rdata    (rdata_i),
        .ldata    (ld_data_o)
    );

    assign acc_valid_o = valid_q;
    assign undef_o     = undef_q;
    assign acc_addr_o  = addr_q;
    assign acc_byte_o  = byte_q;
    assign acc_write_o = write_q;
    assign wb_data_o   = wbd_q;
    assign wb_en_o     = valid_q && wbreq_q && !abort_i;

    AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && is_xfer && !dec.bits.pre) |=> (acc_addr_o == $past(base_i))); // R3
    AST_PRE_WB_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wb_en_o && pre_q) |-> (wb_data_o == acc_addr_o)); // R2
    AST_POST_WB_USER: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && is_xfer && !dec.bits.pre && dec.bits.wb) |=> !trans_o); // R4
    AST_IDLE_TRANS_MODE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_o |-> (trans_o == (mode_i[1:0] != 2'b00))); // R5
    AST_ABORT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> !wb_en_o); // R6
    AST_UNDEF_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (!acc_valid_o && !wb_en_o)); // R7
    AST_ONE_CYCLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> !acc_valid_o); // R8
endmodule

// File: tb/ldst_agu_tb_top.sv
module ldst_agu_tb_top;
    import ldst_agu_pkg::*;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] base;
        logic [31:0] roff;
        logic [31:0] addr;
        logic [31:0] wbd;
        logic        wbe;
        logic        byt;
        logic        wr;
        logic        vld;
        logic        und;
        logic        tlow;
    } vec_t;

    localparam int NV = 10;
    // fields: instr, base, roff, addr, wb data, wb en, byte, write, valid, undef, trans low
    localparam vec_t VEC [NV] = '{
        {32'hE5910010, 32'h00001000, 32'h0, 32'h00001010, 32'h00001010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R7 pre, no wb, imm bit4 set
        {32'hE5B10010, 32'h00001000, 32'h0, 32'h00001010, 32'h00001010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 pre wb
        {32'hE5010004, 32'h00001000, 32'h0, 32'h00000FFC, 32'h00000FFC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 R9 pre down store
        {32'hE4810020, 32'h00002000, 32'h0, 32'h00002000, 32'h00002020, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 post up
        {32'hE4110FFF, 32'h00002000, 32'h0, 32'h00002000, 32'h00001001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 post down imm max
        {32'hE7D10002, 32'h00003000, 32'h5, 32'h00003005, 32'h00003005, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 reg byte load
        {32'hE6E10002, 32'h00003000, 32'h100, 32'h00003000, 32'h00003100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 post wb
        {32'hE7210002, 32'h00000004, 32'h8, 32'hFFFFFFFC, 32'hFFFFFFFC, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R11 wrap
        {32'hE7910012, 32'h00001000, 32'h4, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 undef
        {32'hE3A10010, 32'h00001000, 32'h4, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R1 not a transfer
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid_i;
    logic [31:0] instr_i, base_i, roff_i, rdata_i;
    logic [4:0]  mode_i;
    logic        abort_i;
    logic        acc_valid_o, acc_byte_o, acc_write_o, wb_en_o, trans_o, undef_o;
    logic [31:0] acc_addr_o, wb_data_o, ld_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ldst_agu dut_i (
        .clk(clk), .rst(rst), .dec_valid_i(dec_valid_i), .instr_i(instr_i),
        .base_i(base_i), .roff_i(roff_i), .mode_i(mode_i), .abort_i(abort_i),
        .rdata_i(rdata_i), .acc_valid_o(acc_valid_o), .acc_addr_o(acc_addr_o),
        .acc_byte_o(acc_byte_o), .acc_write_o(acc_write_o), .wb_en_o(wb_en_o),
        .wb_data_o(wb_data_o), .trans_o(trans_o), .undef_o(undef_o), .ld_data_o(ld_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // strobe at a falling edge; leaves the bench at the falling edge of the access cycle
    task automatic strobe(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] ro);
        @(negedge clk);
        dec_valid_i = 1'b1; instr_i = ins; base_i = b; roff_i = ro;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1; dec_valid_i = 1'b0; instr_i = '0; base_i = '0; roff_i = '0;
        mode_i = 5'h13; abort_i = 1'b0; rdata_i = 32'hAABBCCDD;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset valid", {31'b0, acc_valid_o}, 32'd0);
        chk("R8 reset wb_en", {31'b0, wb_en_o}, 32'd0);
        chk("R8 reset undef", {31'b0, undef_o}, 32'd0);
        chk("R5 idle trans priv", {31'b0, trans_o}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i].instr, VEC[i].base, VEC[i].roff);
            #1;
            chk($sformatf("R1 R8 valid v%0d", i), {31'b0, acc_valid_o}, {31'b0, VEC[i].vld});
            chk($sformatf("R7 undef v%0d", i), {31'b0, undef_o}, {31'b0, VEC[i].und});
            chk($sformatf("R2 R3 wb_en v%0d", i), {31'b0, wb_en_o}, {31'b0, VEC[i].wbe});
            if (VEC[i].vld) begin
                chk($sformatf("R2 R3 R11 addr v%0d", i), acc_addr_o, VEC[i].addr);
                chk($sformatf("R9 byte v%0d", i), {31'b0, acc_byte_o}, {31'b0, VEC[i].byt});
                chk($sformatf("R9 write v%0d", i), {31'b0, acc_write_o}, {31'b0, VEC[i].wr});
                chk($sformatf("R4 R5 trans v%0d", i), {31'b0, trans_o}, {31'b0, !VEC[i].tlow});
            end
            if (VEC[i].wbe)
                chk($sformatf("R2 R3 wb_data v%0d", i), wb_data_o, VEC[i].wbd);
            @(negedge clk);
            chk($sformatf("R8 single cycle v%0d", i), {31'b0, acc_valid_o}, 32'd0);
            chk($sformatf("R5 trans after v%0d", i), {31'b0, trans_o}, 32'd1);
        end

        // R6: abort on a post-indexed access drops the base update
        strobe(32'hE4810020, 32'h2000, 32'h0);
        abort_i = 1'b1; #1;
        chk("R6 abort wb_en", {31'b0, wb_en_o}, 32'd0);
        chk("R6 abort access still issued", {31'b0, acc_valid_o}, 32'd1);
        abort_i = 1'b0;

        // R10: byte lane 1 and lane 3, word passthrough
        strobe(32'hE7D10002, 32'h3000, 32'h1); #1;
        chk("R10 byte lane1", ld_data_o, 32'h000000CC);
        strobe(32'hE7D10002, 32'h3000, 32'h3); #1;
        chk("R10 byte lane3", ld_data_o, 32'h000000AA);
        strobe(32'hE5910010, 32'h1000, 32'h0); #1;
        chk("R10 word load", ld_data_o, 32'hAABBCCDD);

        // R4/R5 in user mode: post writeback stays low, idle follows mode
        mode_i = 5'h10;
        @(negedge clk); #1;
        chk("R5 idle trans user", {31'b0, trans_o}, 32'd0);
        mode_i = 5'h12;
        strobe(32'hE4A10004, 32'h100, 32'h0); #1;
        chk("R4 post wb trans low", {31'b0, trans_o}, 32'd0);
        chk("R3 post wb data", wb_data_o, 32'h00000104);
        @(negedge clk); #1;
        chk("R5 trans returns", {31'b0, trans_o}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule